// File: doc/BRIEF.md
# I2C Line Monitor and Force-Low Override

This block sits beside an I2C master engine. It lets software see the SCL and SDA lines and take them over by hand, so that a bus held low by a confused target can be freed. Each raw line passes through a two-flop synchroniser and then a glitch filter. The filter accepts a new level only after that level has held for a programmable number of clock cycles. The two filtered levels appear as read-only status bits in a small four-bit control/status register.

The two upper bits of the same register are force-low overrides, one for each line. The open-drain output enable of each line is the OR of the engine's own drive-low request and the matching override. Software can therefore pull a line low without first taking ownership from the engine. A second register holds the filter length in clock cycles. Software makes the recovery pulses by writing the override bits; the block does not time them.

Register layout, four bits: bit 0 is the filtered SCL level, bit 1 is the filtered SDA level, bit 2 is the SCL override and bit 3 is the SDA override.

Top module: `i2c_line_guard`

## Requirements
- R1: After reset the status bits read 1 (both lines idle high), both override bits read 0, and both output enables are 0 while the engine requests nothing. The filter length holds the value of the reset parameter.
- R2: Bit 0 of `reg_rdata` shows the filtered SCL level and bit 1 shows the filtered SDA level. With filter length L, a pin level held steady is first seen at the clock edge that comes max(L,1)+1 edges after the edge that first samples it.
- R3: Bit 2 of `reg_rdata` reads back the SCL override and bit 3 reads back the SDA override. A write (`reg_wr` high) loads both overrides from `reg_wdata[3:2]`, and the new values appear after that edge.
- R4: An override bit at 1 asserts that line's open-drain enable (line pulled low). An override bit at 0 releases the line unless the engine drives it.
- R5: Each line's output enable is the OR of the engine drive-low request and the override bit. An engine request alone asserts the enable, with no cycle of delay.
- R6: The values written to bits 1:0 have no effect. The status bits continue to show the filtered pin levels.
- R7: With filter length L of 1 or more, a new synchronised level is accepted only after it has been seen on L consecutive samples. A pulse shorter than L cycles never reaches the status bits. A pulse of exactly L cycles does reach them.
- R8: A filter length of 0 passes the synchronised level with no filtering, so even a one-cycle pulse reaches the status bit.
- R9: A write on `len_wr` loads `len_wdata` as the filter length, and the new length is used from the next clock cycle on.
- R10: A write that sets bit 2 and carries the present SDA override value in bit 3 changes only the SCL override. The SDA override and `sda_oe` keep their values.
- R11: The two lines are filtered independently. A change on one pin never changes the other line's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| eng_scl_low | input | 1 | Engine request to drive SCL low |
| eng_sda_low | input | 1 | Engine request to drive SDA low |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 4 | Write data; only bits 3:2 are stored |
| reg_rdata | output | 4 | {SDA override, SCL override, filtered SDA, filtered SCL} |
| len_wr | input | 1 | Write strobe for the filter length |
| len_wdata | input | LEN_W | New filter length in clock cycles |
| scl_oe | output | 1 | SCL open-drain enable (1 pulls low) |
| sda_oe | output | 1 | SDA open-drain enable (1 pulls low) |

## Verification
The bench builds the block with a four-bit length field and a reset length of 3. This keeps the whole length range, including the maximum of 15 and the pass-through value 0, within a few cycles of each test. With these values the exact acceptance edge can be counted by hand, and pulses one cycle shorter than, and equal to, the length can both be placed. A random phase that changes the length while pulses are in flight then compares every cycle with a reference model of the filter.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;

    localparam int REG_W       = 4;
    localparam int NUM_LINES   = 2;
    localparam int LINE_SCL    = 0;
    localparam int LINE_SDA    = 1;
    localparam int BIT_SCL_LVL = 0;
    localparam int BIT_SDA_LVL = 1;
    localparam int BIT_SCL_CTL = 2;
    localparam int BIT_SDA_CTL = 3;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_pair_t;

    function automatic line_pair_t to_pair(input logic [NUM_LINES-1:0] v);
        line_pair_t p;
        p.scl = v[LINE_SCL];
        p.sda = v[LINE_SDA];
        return p;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input line_pair_t ctl,
                                                     input line_pair_t lvl);
        logic [REG_W-1:0] r;
        r[BIT_SCL_LVL] = lvl.scl;
        r[BIT_SDA_LVL] = lvl.sda;
        r[BIT_SCL_CTL] = ctl.scl;
        r[BIT_SDA_CTL] = ctl.sda;
        return r;
    endfunction

endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
    parameter int   STAGES  = 2,
    parameter int   W       = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= {W{RST_VAL}};
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/guard_filter.sv
module guard_filter #(
    parameter int   LEN_W   = 8,
    parameter logic RST_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp,
    input  logic [LEN_W-1:0] len,
    output logic             lvl
);
    logic [LEN_W-1:0] run_q;
    logic             lvl_q;
    logic [LEN_W:0]   seen;

    // number of consecutive differing samples including the current one
    assign seen = {1'b0, run_q} + {{LEN_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= RST_LVL;
            run_q <= '0;
        end else if (smp == lvl_q) begin
            run_q <= '0;
        end else if (seen >= {1'b0, len}) begin
            lvl_q <= smp;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign lvl = lvl_q;
endmodule

// File: rtl/guard_ctl.sv
module guard_ctl
    import i2c_guard_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int RST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  line_pair_t       wr_ctl,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    input  line_pair_t       eng_low,
    output line_pair_t       ctl,
    output logic [LEN_W-1:0] len,
    output line_pair_t       oe
);
    line_pair_t       ctl_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            len_q <= LEN_W'(RST_LEN);
        end else begin
            if (reg_wr) ctl_q <= wr_ctl;
            if (len_wr) len_q <= len_wdata;
        end
    end

    always_comb begin
        oe.scl = eng_low.scl | ctl_q.scl;
        oe.sda = eng_low.sda | ctl_q.sda;
    end

    assign ctl = ctl_q;
    assign len = len_q;
endmodule

// File: rtl/i2c_line_guard.sv
module i2c_line_guard
    import i2c_guard_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int RST_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             eng_scl_low,
    input  logic             eng_sda_low,
    input  logic             reg_wr,
    input  logic [3:0]       reg_wdata,
    output logic [3:0]       reg_rdata,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic [NUM_LINES-1:0] raw;
    logic [NUM_LINES-1:0] synced;
    logic [NUM_LINES-1:0] level;
    logic [LEN_W-1:0]     len;
    line_pair_t           wr_ctl;
    line_pair_t           eng_low;
    line_pair_t           ctl;
    line_pair_t           oe;
    logic                 unused_status_wr;

    assign raw[LINE_SCL] = scl_in;
    assign raw[LINE_SDA] = sda_in;

    // the status field is read-only; its write bits are dropped here
    assign unused_status_wr = ^reg_wdata[BIT_SDA_LVL:BIT_SCL_LVL];
    assign wr_ctl.scl  = reg_wdata[BIT_SCL_CTL];
    assign wr_ctl.sda  = reg_wdata[BIT_SDA_CTL];
    assign eng_low.scl = eng_scl_low;
    assign eng_low.sda = eng_sda_low;

    guard_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (NUM_LINES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            guard_filter #(
                .LEN_W   (LEN_W),
                .RST_LVL (1'b1)
            ) u_filt (
                .clk (clk),
                .rst (rst),
                .smp (synced[i]),
                .len (len),
                .lvl (level[i])
            );
        end
    endgenerate

    guard_ctl #(
        .LEN_W   (LEN_W),
        .RST_LEN (RST_LEN)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .wr_ctl    (wr_ctl),
        .len_wr    (len_wr),
        .len_wdata (len_wdata),
        .eng_low   (eng_low),
        .ctl       (ctl),
        .len       (len),
        .oe        (oe)
    );

    assign reg_rdata = pack_status(ctl, to_pair(level));
    assign scl_oe    = oe.scl;
    assign sda_oe    = oe.sda;
endmodule

// File: rtl/i2c_line_guard_chk.sv
module i2c_line_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_in,
    input logic       eng_scl_low,
    input logic       eng_sda_low,
    input logic       reg_wr,
    input logic [3:0] reg_wdata,
    input logic [3:0] reg_rdata,
    input logic       scl_oe,
    input logic       sda_oe
);
    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> reg_rdata[3:2] == $past(reg_wdata[3:2])); // R3

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(reg_rdata[3:2])); // R10

    AST_FORCE_SCL: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[2]) |=> scl_oe); // R4

    AST_FORCE_SDA: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[3]) |=> sda_oe); // R4

    AST_ENGINE_SCL: assert property (@(posedge clk) disable iff (rst)
        eng_scl_low |-> scl_oe); // R5

    AST_ENGINE_SDA: assert property (@(posedge clk) disable iff (rst)
        eng_sda_low |-> sda_oe); // R5

    AST_SCL_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] != $past(reg_rdata[0])) |-> reg_rdata[0] == $past(scl_in, 3)); // R2

    AST_SDA_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1] != $past(reg_rdata[1])) |-> reg_rdata[1] == $past(sda_in, 3)); // R11
endmodule

bind i2c_line_guard i2c_line_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .eng_scl_low (eng_scl_low),
    .eng_sda_low (eng_sda_low),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe)
);

// File: tb/i2c_line_guard_test.sv
module i2c_line_guard_test;
    localparam int CLK_P   = 10;
    localparam int LEN_W   = 4;
    localparam int RST_LEN = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             scl_in = 1'b1;
    logic             sda_in = 1'b1;
    logic             eng_scl_low = 1'b0;
    logic             eng_sda_low = 1'b0;
    logic             reg_wr = 1'b0;
    logic [3:0]       reg_wdata = '0;
    logic [3:0]       reg_rdata;
    logic             len_wr = 1'b0;
    logic [LEN_W-1:0] len_wdata = '0;
    logic             scl_oe;
    logic             sda_oe;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    i2c_line_guard #(.LEN_W(LEN_W), .RST_LEN(RST_LEN)) uut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .len_wr(len_wr), .len_wdata(len_wdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // reference model of the requirements (R2, R3, R7, R8, R9)
    logic [1:0]       m_s1, m_s2, m_lvl, m_ctl;
    int               m_run [2];
    int               m_len;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 2'b11; m_s2 <= 2'b11; m_lvl <= 2'b11; m_ctl <= 2'b00;
            m_run[0] <= 0; m_run[1] <= 0; m_len <= RST_LEN;
        end else begin
            m_s1 <= {sda_in, scl_in};
            m_s2 <= m_s1;
            for (int i = 0; i < 2; i++) begin
                if (m_s2[i] == m_lvl[i]) m_run[i] <= 0;
                else if (m_run[i] + 1 >= m_len) begin
                    m_lvl[i] <= m_s2[i]; m_run[i] <= 0;
                end else m_run[i] <= m_run[i] + 1;
            end
            if (reg_wr) m_ctl <= reg_wdata[3:2];
            if (len_wr) m_len <= int'(len_wdata);
        end
    end

    function automatic logic exp_oe(input logic eng, input logic ctl);
        return eng | ctl;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_reg(input logic [3:0] v);
        reg_wr = 1'b1; reg_wdata = v; tick(); reg_wr = 1'b0;
    endtask

    task automatic write_len(input int v);
        len_wr = 1'b1; len_wdata = LEN_W'(v); tick(); len_wr = 1'b0;
    endtask

    // hold a new SCL level and count edges to acceptance
    task automatic latency_check(input int l, input string req);
        int need = (l < 1 ? 1 : l) + 2;
        scl_in = 1'b0;
        ticks(need - 1);
        check(reg_rdata[0] == 1'b1, req, reg_rdata[0], 1);
        tick();
        check(reg_rdata[0] == 1'b0, req, reg_rdata[0], 0);
        scl_in = 1'b1;
        ticks(need + 1);
        check(reg_rdata[0] == 1'b1, req, reg_rdata[0], 1);
    endtask

    task automatic pulse_scl(input int width, input bit expect_seen, input string req);
        bit seen = 0;
        scl_in = 1'b0;
        for (int i = 0; i < width; i++) begin
            tick();
            if (reg_rdata[0] == 1'b0) seen = 1;
        end
        scl_in = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (reg_rdata[0] == 1'b0) seen = 1;
        end
        check(seen == expect_seen, req, seen, expect_seen);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hold_s, hold_d;
        @(negedge clk);
        ticks(4);
        rst = 1'b0;
        tick();

        // R1 reset state
        check(reg_rdata == 4'b0011, "R1 reset register", reg_rdata, 4'b0011);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 reset enables", {sda_oe, scl_oe}, 0);
        latency_check(RST_LEN, "R1 reset length");

        // R9 / R2 / R7 latency with programmed lengths
        write_len(2);
        latency_check(2, "R9 length 2");
        write_len(15);
        latency_check(15, "R7 max length");
        write_len(5);
        latency_check(5, "R2 length 5");

        // R7 pulse rejection and acceptance
        write_len(4);
        pulse_scl(3, 1'b0, "R7 short pulse");
        pulse_scl(4, 1'b1, "R7 exact pulse");

        // R8 zero length
        write_len(0);
        latency_check(0, "R8 length 0");
        scl_in = 1'b0; tick(); scl_in = 1'b1; tick(); tick();
        check(reg_rdata[0] == 1'b0, "R8 one-cycle pulse", reg_rdata[0], 0);
        tick();
        check(reg_rdata[0] == 1'b1, "R8 pulse end", reg_rdata[0], 1);

        // R11 independence
        sda_in = 1'b0; ticks(4);
        check(reg_rdata[1:0] == 2'b01, "R11 sda low only", reg_rdata[1:0], 2'b01);
        sda_in = 1'b1; ticks(4);

        // R3 / R4 overrides
        write_reg(4'b0100);
        check(reg_rdata[3:2] == 2'b01, "R3 scl ctl readback", reg_rdata[3:2], 2'b01);
        check(scl_oe == 1'b1 && sda_oe == 1'b0, "R4 scl forced", {sda_oe, scl_oe}, 2'b01);
        // R10 read-modify-write preserves SDA
        write_reg(4'b1100);
        write_reg({reg_rdata[3], 1'b0, 2'b00});
        check(reg_rdata[3:2] == 2'b10, "R10 sda preserved", reg_rdata[3:2], 2'b10);
        check(sda_oe == 1'b1 && scl_oe == 1'b0, "R10 enables", {sda_oe, scl_oe}, 2'b10);
        // R6 status write ignored
        write_reg(4'b0000);
        ticks(2);
        check(reg_rdata == 4'b0011, "R6 status ignores write", reg_rdata, 4'b0011);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R4 release", {sda_oe, scl_oe}, 0);

        // R5 engine merge
        eng_scl_low = 1'b1; #1;
        check(scl_oe == 1'b1 && sda_oe == 1'b0, "R5 engine scl", {sda_oe, scl_oe}, 2'b01);
        eng_scl_low = 1'b0; eng_sda_low = 1'b1; write_reg(4'b1000);
        check(sda_oe == 1'b1, "R5 both sources", sda_oe, 1);
        eng_sda_low = 1'b0; #1;
        check(sda_oe == 1'b1, "R5 override alone", sda_oe, 1);
        write_reg(4'b0000);
        check(sda_oe == 1'b0, "R5 neither", sda_oe, 0);

        // random phase against the model
        void'($urandom(32'h5EED_1234));
        hold_s = 0; hold_d = 0;
        for (int c = 0; c < 4000; c++) begin
            check(reg_rdata == {m_ctl, m_lvl}, "R2 R7 R9 model", reg_rdata, {m_ctl, m_lvl});
            check(scl_oe == exp_oe(eng_scl_low, m_ctl[0]) && sda_oe == exp_oe(eng_sda_low, m_ctl[1]),
                  "R5 model", {sda_oe, scl_oe},
                  {exp_oe(eng_sda_low, m_ctl[1]), exp_oe(eng_scl_low, m_ctl[0])});
            if (hold_s == 0) begin scl_in = $urandom_range(0, 1); hold_s = $urandom_range(1, 12); end
            else hold_s--;
            if (hold_d == 0) begin sda_in = $urandom_range(0, 1); hold_d = $urandom_range(1, 12); end
            else hold_d--;
            eng_scl_low = ($urandom_range(0, 7) == 0);
            eng_sda_low = ($urandom_range(0, 7) == 0);
            reg_wr      = ($urandom_range(0, 15) == 0);
            reg_wdata   = 4'($urandom_range(0, 15));
            len_wr      = ($urandom_range(0, 199) == 0);
            len_wdata   = LEN_W'($urandom_range(0, 8));
            tick();
        end
        reg_wr = 1'b0; len_wr = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule